// File: doc/BRIEF.md
# Watchdog Timer with Paired-Command Clear

This block is the watchdog of a small microcontroller core. It counts system-clock cycles through a power-of-two prescaler and a main counter. When the main counter rolls over from all-ones to zero, the block emits a one-cycle time-out pulse, which the reset sequencer turns into a chip reset. It also sets a sticky flag for the status logic. After a time-out the count restarts from zero.

Software keeps the watchdog quiet by issuing clear commands, which the instruction decoder turns into one-cycle strobes. A static mode pin picks the clearing scheme:
- **Single mode:** one command strobe restarts the count.
- **Paired mode:** two distinct command strobes, A and B, must both be seen before the count restarts. They may come in either order or in the same cycle. A half that arrives alone is remembered until its partner arrives.

A halt input, raised while the core sleeps, freezes the main counter and holds the prescaler at zero. Every port is a plain control or status pin. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `wdog_pair_clear`

## Requirements
- R1: While `rst_n` is low, `timeout_o` and `to_flag_o` are 0, and the prescaler, the main counter and any remembered half-clear are zero.
- R2: With no clear and no halt, `timeout_o` is high for exactly one cycle, after the 2^PRE_W × 2^CNT_W-th rising edge that counts since reset release or since the last completed clear. Counting then restarts from zero, so further pulses follow at the same period.
- R3: With `dual_mode_i` = 0, a high `clr_one_i` at a rising edge zeroes the prescaler and the main counter at that edge. In this mode `clr_a_i` and `clr_b_i` have no effect.
- R4: With `dual_mode_i` = 1, `clr_one_i` has no effect, and a lone A strobe or a lone B strobe leaves the count untouched.
- R5: With `dual_mode_i` = 1, the clear completes at the edge where the second of A and B is seen. The halves may arrive in either order or together. Completion zeroes the prescaler and the main counter.
- R6: A remembered half-clear is discarded when a clear completes and on reset. A later lone half therefore does not clear the count.
- R7: While `halt_i` is high, the main counter holds its value and no time-out occurs.
- R8: While `halt_i` is high, the prescaler is held at zero. After release, the first prescaler carry comes 2^PRE_W edges later.
- R9: `to_flag_o` rises together with `timeout_o` and stays high until a clear completes or reset is applied.
- R10: A clear that completes at the same edge as a would-be roll-over wins: no pulse is produced and the count restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode_i | input | 1 | Static scheme select: 0 single command, 1 paired commands |
| clr_one_i | input | 1 | Single clear command strobe |
| clr_a_i | input | 1 | First half of the paired clear |
| clr_b_i | input | 1 | Second half of the paired clear |
| halt_i | input | 1 | Core sleeping: freeze counter, hold prescaler at zero |
| timeout_o | output | 1 | One-cycle time-out pulse |
| to_flag_o | output | 1 | Sticky time-out flag for status logic |

## Verification
The embedded assertions check the following on every cycle:
- the time-out is a one-cycle pulse, and the count is back at zero with it;
- the two remembered halves are never held together;
- a lone half or an off-mode strobe never fires a clear;
- a completed clear suppresses the pulse;
- halt freezes the counter and holds the prescaler at zero.

Only the bench scenarios can show that the end-to-end period is right. The same holds for:
- the restart point after a clear in each order;
- halt shifting the next time-out by the prescaler phase it discards;
- a half-clear remembered across an unrelated completion or a reset staying discarded.

The bench shows these through the exact edge at which each pulse appears.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    WDT_MODE_SINGLE = 1'b0,
    WDT_MODE_PAIRED = 1'b1
  } wdt_mode_e;

  localparam int WDT_PRE_W_DEF = 8;
  localparam int WDT_CNT_W_DEF = 8;
endpackage

// File: rtl/wdt_clear_arbiter.sv
module wdt_clear_arbiter
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wdt_mode_e mode,
  input  logic      clr_one,
  input  logic      clr_a,
  input  logic      clr_b,
  output logic      clear_fire
);
  logic pend_a, pend_b;
  logic have_a, have_b;
  logic fire_single, fire_paired;

  assign have_a      = clr_a | pend_a;
  assign have_b      = clr_b | pend_b;
  assign fire_single = (mode == WDT_MODE_SINGLE) & clr_one;
  assign fire_paired = (mode == WDT_MODE_PAIRED) & have_a & have_b;
  assign clear_fire  = fire_single | fire_paired;

  always_ff @(posedge clk) begin
    if (!rst_n || mode != WDT_MODE_PAIRED || fire_paired) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else begin
      pend_a <= have_a;
      pend_b <= have_b;
    end
  end

  AST_NO_DOUBLE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_a && pend_b)); // R6
  AST_HALF_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WDT_MODE_PAIRED && clr_a && !clr_b && !pend_b) |-> !clear_fire); // R4
  AST_ONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WDT_MODE_PAIRED && clr_one && !have_a) |-> !clear_fire); // R4
  AST_PAIR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WDT_MODE_SINGLE && !clr_one) |-> !clear_fire); // R3
  AST_PEND_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    fire_paired |=> (!pend_a && !pend_b)); // R6
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic clear,
  output logic tick
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  assign tick = !halt && !clear && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || halt || clear) pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end

  AST_HALT_PRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (pre_q == '0)); // R8
  AST_CLEAR_PRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_q == '0)); // R3
endmodule

// File: rtl/wdt_main_counter.sv
module wdt_main_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             clear,
  input  logic             tick,
  output logic             wrap,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign wrap  = tick && (cnt_q == CNT_LAST);
  assign count = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (tick)       cnt_q <= cnt_q + 1'b1;
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clear) |=> $stable(cnt_q)); // R7
  AST_HALT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !wrap); // R7
endmodule

// File: rtl/wdog_pair_clear.sv
module wdog_pair_clear
  import wdt_pkg::*;
#(
  parameter int PRE_W = WDT_PRE_W_DEF,
  parameter int CNT_W = WDT_CNT_W_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dual_mode_i,
  input  logic clr_one_i,
  input  logic clr_a_i,
  input  logic clr_b_i,
  input  logic halt_i,
  output logic timeout_o,
  output logic to_flag_o
);
  wdt_mode_e        mode;
  logic             clear_fire;
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] count;
  logic             timeout_q, flag_q;

  assign mode = wdt_mode_e'(dual_mode_i);

  wdt_clear_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .clr_one    (clr_one_i),
    .clr_a      (clr_a_i),
    .clr_b      (clr_b_i),
    .clear_fire (clear_fire)
  );

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .halt  (halt_i),
    .clear (clear_fire),
    .tick  (tick)
  );

  wdt_main_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .halt  (halt_i),
    .clear (clear_fire),
    .tick  (tick),
    .wrap  (wrap),
    .count (count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timeout_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      timeout_q <= wrap;
      if (clear_fire) flag_q <= 1'b0;
      else if (wrap)  flag_q <= 1'b1;
    end
  end

  assign timeout_o = timeout_q;
  assign to_flag_o = flag_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (count == '0)); // R2
  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> to_flag_o); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_fire |=> (!timeout_o && !to_flag_o)); // R10
endmodule

// File: tb/sim_wdog_pair_clear.sv
module sim_wdog_pair_clear;
  localparam int PW = 2;
  localparam int CW = 3;
  localparam int PERIOD = (1 << PW) * (1 << CW); // 32 edges

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dual_mode_i = 1'b0;
  logic clr_one_i = 1'b0, clr_a_i = 1'b0, clr_b_i = 1'b0;
  logic halt_i = 1'b0;
  logic timeout_o, to_flag_o;

  always #2.5 clk = ~clk; // 200 MHz

  wdog_pair_clear #(.PRE_W(PW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .dual_mode_i(dual_mode_i),
    .clr_one_i(clr_one_i), .clr_a_i(clr_a_i), .clr_b_i(clr_b_i),
    .halt_i(halt_i), .timeout_o(timeout_o), .to_flag_o(to_flag_o)
  );

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  int    expq[$];
  string req_tag = "R1";
  logic  prev_to = 1'b0;
  bit    done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic fail_msg(input string req, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
  endtask

  task automatic check_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) fail_msg(req, act, exp);
  endtask

  // Monitor: pops expected time-out edges and compares them with observed pulses.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (timeout_o) begin
        checks++;
        if (expq.size() == 0) fail_msg(req_tag, cyc, -1);
        else if (expq[0] != cyc) fail_msg(req_tag, cyc, expq[0]);
        else void'(expq.pop_front());
        if (prev_to) fail_msg("R2", 1, 0); // pulse longer than one cycle
      end
      prev_to <= timeout_o;
    end
  end

  task automatic expect_at(input int edge_n);
    expq.push_back(edge_n);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic reset_dut(input logic dual, input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    dual_mode_i = dual;
    clr_one_i = 0; clr_a_i = 0; clr_b_i = 0; halt_i = 0;
    repeat (3) @(negedge clk);
    check_val("R1", int'(timeout_o), 0);
    check_val("R1", int'(to_flag_o), 0);
    expq.delete();
    req_tag = tag;
    rst_n = 1'b1;
  endtask

  // which: 0 single command, 1 half A, 2 half B, 3 both halves; acts at edge_n
  task automatic strobe(input int which, input int edge_n);
    wait_to(edge_n - 1);
    clr_one_i = (which == 0);
    clr_a_i   = (which == 1) || (which == 3);
    clr_b_i   = (which == 2) || (which == 3);
    @(negedge clk);
    clr_one_i = 0; clr_a_i = 0; clr_b_i = 0;
  endtask

  task automatic end_scen(input int n);
    wait_to(n);
    check_val({req_tag, " pending"}, expq.size(), 0);
  endtask

  initial begin
    // R2 free run, R9 flag behaviour
    reset_dut(1'b0, "R2");
    expect_at(PERIOD); expect_at(2 * PERIOD);
    wait_to(40);
    check_val("R9", int'(to_flag_o), 1);
    end_scen(2 * PERIOD + 6);
    strobe(0, 2 * PERIOD + 8);
    @(negedge clk);
    check_val("R9", int'(to_flag_o), 0);

    // R3 single command restarts count
    reset_dut(1'b0, "R3");
    strobe(0, 20); expect_at(20 + PERIOD);
    end_scen(60);

    // R3 paired halves ignored in single mode
    reset_dut(1'b0, "R3");
    strobe(1, 10); strobe(2, 15); expect_at(PERIOD);
    end_scen(40);

    // R4 single command and lone halves ignored in paired mode
    reset_dut(1'b1, "R4");
    strobe(0, 10); strobe(1, 20); expect_at(PERIOD);
    strobe(0, 35); expect_at(2 * PERIOD);
    end_scen(70);

    // R5 A then B
    reset_dut(1'b1, "R5");
    strobe(1, 10); strobe(2, 20); expect_at(20 + PERIOD);
    end_scen(56);

    // R5 B then A
    reset_dut(1'b1, "R5");
    strobe(2, 5); strobe(1, 12); expect_at(12 + PERIOD);
    end_scen(50);

    // R5 both in one cycle
    reset_dut(1'b1, "R5");
    strobe(3, 15); expect_at(15 + PERIOD);
    end_scen(50);

    // R6 pending discarded at completion
    reset_dut(1'b1, "R6");
    strobe(1, 5); strobe(2, 8); expect_at(8 + PERIOD);
    strobe(2, 20);
    end_scen(45);

    // R6 pending discarded by reset
    reset_dut(1'b1, "R6");
    strobe(1, 10);
    reset_dut(1'b1, "R6");
    strobe(2, 5); expect_at(PERIOD);
    end_scen(40);

    // R7 / R8 halt over edges 10..19: counter frozen at 2, prescaler restarts
    reset_dut(1'b0, "R8");
    wait_to(9); halt_i = 1'b1;
    wait_to(19); halt_i = 1'b0;
    expect_at(43);
    end_scen(50);

    // R10 clear at the roll-over edge wins
    reset_dut(1'b0, "R10");
    strobe(0, PERIOD); expect_at(2 * PERIOD);
    wait_to(PERIOD + 2);
    check_val("R10", int'(to_flag_o), 0);
    end_scen(2 * PERIOD + 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule